// File: doc/BRIEF.md
# Host Direct-I/O Register Port

This block is the slave side of a strobe-driven host bus. It lets a host processor read and write a small bank of 16-bit registers inside the chip. The host drives an active-low chip select, a 4-bit register select, an active-low byte-high enable and an address strobe. Data moves under separate active-low read and write strobes. All of these inputs are asynchronous to the internal clock, so each one passes through a two-flop synchronizer before any logic in the clock domain acts on it.

The select inputs pass through a latch before they are decoded. While the synchronized address strobe is high, the latch follows its inputs. When the strobe falls, the latch holds what it last saw, and it keeps holding while the strobe stays low. A host with no address strobe ties it high and presents the selects directly.

A three-state controller handles each access. `IDLE` moves to `READ` on a detected falling read strobe while the port is selected. `IDLE` moves to `WRITE` on a detected falling write strobe while the port is selected. Both `READ` and `WRITE` return to `IDLE` once both synchronized strobes are high again. A write commits on the detected rising edge of the write strobe while the controller is in `WRITE`. Ready is driven low throughout `READ` and `WRITE`. Read data is driven, with its enable, throughout `READ`.

Top module: `hdio_port`

## Requirements
- R1: While the synchronized address strobe is high, the latched chip select, register select and byte-high enable follow the synchronized inputs on every clock.
- R2: After the synchronized address strobe falls, the latched selects stay constant until it rises again. Select changes made in that time have no effect on which register is accessed.
- R3: With the address strobe held high throughout, reads and writes work with the selects presented directly.
- R4: Register select bit 3 is the most significant bit. Bits 3..1 pick one of 8 words. Bit 0 picks the byte: 0 is the low byte (data bits 7..0) and 1 is the high byte (data bits 15..8).
- R5: A selected write updates the register on the rising edge of the write strobe. A write while chip select is high (deselected) changes no register.
- R6: While a selected read is in progress, `rdata_oe` is 1 and `rdata` carries the addressed word. At all other times `rdata_oe` is 0 and `rdata` is 0.
- R7: `rdy_n` falls one clock after a falling read or write strobe edge is detected while the port is selected. It never falls for a deselected access.
- R8: `rdy_n` returns high on the clock after both synchronized strobes are seen high.
- R9: A write to an even address with byte-high enable 0 updates both bytes of the word from `wdata[15:0]`. Any other write updates only the addressed byte: an even address takes `wdata[7:0]`, and an odd address takes `wdata[15:8]`.
- R10: After reset, `rdy_n` is 1, `rdata_oe` is 0 and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rsel | input | 4 | Register select, bit 3 most significant |
| bhe_n | input | 1 | Byte-high enable, active low |
| as_i | input | 1 | Address strobe; high means the latch is transparent |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; a write commits on its rising edge |
| wdata | input | 16 | Write data from the host |
| rdata | output | 16 | Read data to the host |
| rdata_oe | output | 1 | Read data output enable |
| rdy_n | output | 1 | Ready/acknowledge, active low |

## Verification
The bound checker watches several rules on every clock:
- the latch follows its inputs while the strobe is high and holds while it is low;
- register writes happen only on a synchronized write-strobe rising edge;
- a two-lane write happens only for an even address with byte-high enable low;
- ready falls only after a detected selected strobe edge and is released after both strobes are high;
- the data enable never appears without ready.

Some behaviour can only be shown by the bench's scenarios, which read the registers back through the port. These are the byte-lane merge results, the selects changing after the strobe falls without redirecting the access, transparent operation with the strobe tied high, and deselected writes leaving the registers unchanged.

// File: rtl/hdio_pkg.sv
package hdio_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } hdio_state_t;
endpackage

// File: rtl/hdio_sync.sv
module hdio_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage[g] <= RST_VAL;
                    else        stage[g] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage[g] <= RST_VAL;
                    else        stage[g] <= stage[g-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/hdio_sel_latch.sv
module hdio_sel_latch #(
    parameter int          W       = 6,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         open_i,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= RST_VAL;
        else if (open_i) q <= d;
    end
endmodule

// File: rtl/hdio_regfile.sv
module hdio_regfile #(
    parameter int DW     = 16,
    parameter int NWORDS = 8,
    localparam int IW    = $clog2(NWORDS),
    localparam int BW    = DW / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] idx,
    input  logic          we_lo,
    input  logic          we_hi,
    input  logic [BW-1:0] lo_byte,
    input  logic [BW-1:0] hi_byte,
    output logic [DW-1:0] rword
);
    logic [DW-1:0] mem [NWORDS];

    genvar w;
    generate
        for (w = 0; w < NWORDS; w++) begin : g_word
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mem[w] <= '0;
                end else if (idx == IW'(w)) begin
                    if (we_lo) mem[w][BW-1:0]  <= lo_byte;
                    if (we_hi) mem[w][DW-1:BW] <= hi_byte;
                end
            end
        end
    endgenerate

    assign rword = mem[idx];
endmodule

// File: rtl/hdio_fsm.sv
module hdio_fsm
    import hdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sel,
    input  logic        rd_s,
    input  logic        wr_s,
    output logic        rd_fall,
    output logic        wr_fall,
    output logic        wr_rise,
    output logic        commit,
    output logic        rdy_n,
    output logic        drive,
    output hdio_state_t state
);
    hdio_state_t nxt;
    logic        rd_prev;
    logic        wr_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_prev <= 1'b1;
            wr_prev <= 1'b1;
        end else begin
            rd_prev <= rd_s;
            wr_prev <= wr_s;
        end
    end

    assign rd_fall = rd_prev & ~rd_s;
    assign wr_fall = wr_prev & ~wr_s;
    assign wr_rise = ~wr_prev & wr_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (sel && rd_fall)      nxt = ST_READ;
                else if (sel && wr_fall) nxt = ST_WRITE;
            end
            ST_READ:  if (rd_s && wr_s) nxt = ST_IDLE;
            ST_WRITE: if (rd_s && wr_s) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        rdy_n  = 1'b1;
        drive  = 1'b0;
        commit = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_READ: begin
                rdy_n = 1'b0;
                drive = 1'b1;
            end
            ST_WRITE: begin
                rdy_n  = 1'b0;
                commit = wr_rise;
            end
            default:  ;
        endcase
    end
endmodule

// File: rtl/hdio_port.sv
module hdio_port
    import hdio_pkg::*;
#(
    parameter int DW     = 16,
    parameter int SEL_W  = 4,
    parameter int STAGES = 2,
    localparam int NWORDS = 2 ** (SEL_W - 1),
    localparam int BW     = DW / 2,
    localparam int LW     = SEL_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic [SEL_W-1:0] rsel,
    input  logic             bhe_n,
    input  logic             as_i,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             rdata_oe,
    output logic             rdy_n
);
    localparam logic [LW-1:0] SEL_RST = {1'b1, 1'b1, {SEL_W{1'b0}}};

    logic [2:0]    strb_s;
    logic          as_s, rd_s, wr_s;
    logic [LW-1:0] sel_s, sel_q;
    logic [DW-1:0] wdata_s;
    logic          lcs_n, lbhe_n;
    logic [SEL_W-1:0] lsel;
    logic          rd_fall, wr_fall, wr_rise, commit, drive;
    logic          we_lo, we_hi;
    logic [DW-1:0] rword;
    hdio_state_t   fsm_state;

    hdio_sync #(.W(3), .STAGES(STAGES), .RST_VAL(3'b111)) u_sync_strb (
        .clk(clk), .rst_n(rst_n), .d({as_i, rd_n, wr_n}), .q(strb_s)
    );
    assign {as_s, rd_s, wr_s} = strb_s;

    hdio_sync #(.W(LW), .STAGES(STAGES), .RST_VAL(SEL_RST)) u_sync_sel (
        .clk(clk), .rst_n(rst_n), .d({cs_n, bhe_n, rsel}), .q(sel_s)
    );

    hdio_sync #(.W(DW), .STAGES(STAGES), .RST_VAL('0)) u_sync_wd (
        .clk(clk), .rst_n(rst_n), .d(wdata), .q(wdata_s)
    );

    hdio_sel_latch #(.W(LW), .RST_VAL(SEL_RST)) u_latch (
        .clk(clk), .rst_n(rst_n), .open_i(as_s), .d(sel_s), .q(sel_q)
    );
    assign {lcs_n, lbhe_n, lsel} = sel_q;

    hdio_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sel(~lcs_n), .rd_s(rd_s), .wr_s(wr_s),
        .rd_fall(rd_fall), .wr_fall(wr_fall), .wr_rise(wr_rise),
        .commit(commit), .rdy_n(rdy_n), .drive(drive), .state(fsm_state)
    );

    assign we_lo = commit & ~lsel[0];
    assign we_hi = commit & (lsel[0] | ~lbhe_n);

    hdio_regfile #(.DW(DW), .NWORDS(NWORDS)) u_rf (
        .clk(clk), .rst_n(rst_n), .idx(lsel[SEL_W-1:1]),
        .we_lo(we_lo), .we_hi(we_hi),
        .lo_byte(wdata_s[BW-1:0]), .hi_byte(wdata_s[DW-1:BW]),
        .rword(rword)
    );

    assign rdata_oe = drive;
    assign rdata    = drive ? rword : '0;
endmodule

// File: rtl/hdio_port_chk.sv
module hdio_port_chk #(
    parameter int LW    = 6,
    parameter int SEL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             as_s,
    input logic             rd_s,
    input logic             wr_s,
    input logic [LW-1:0]    sel_s,
    input logic [LW-1:0]    sel_q,
    input logic             lcs_n,
    input logic             lbhe_n,
    input logic [SEL_W-1:0] lsel,
    input logic             rd_fall,
    input logic             wr_fall,
    input logic             we_lo,
    input logic             we_hi,
    input logic             rdy_n,
    input logic             rdata_oe
);
    AST_LATCH_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(as_s) |-> sel_q == $past(sel_s)); // R1
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_s && !$past(as_s)) |-> $stable(sel_q)); // R2
    AST_WRITE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (we_lo || we_hi) |-> (wr_s && !$past(wr_s) && !lcs_n)); // R5
    AST_OE_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe |-> !rdy_n); // R6
    AST_READY_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_n) |-> $past(!lcs_n && (rd_fall || wr_fall))); // R7
    AST_READY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_n && rd_s && wr_s) |=> rdy_n); // R8
    AST_WORD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we_lo && we_hi) |-> (!lbhe_n && !lsel[0])); // R9
endmodule

bind hdio_port hdio_port_chk #(.LW(LW), .SEL_W(SEL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .as_s(as_s), .rd_s(rd_s), .wr_s(wr_s),
    .sel_s(sel_s), .sel_q(sel_q), .lcs_n(lcs_n), .lbhe_n(lbhe_n), .lsel(lsel),
    .rd_fall(rd_fall), .wr_fall(wr_fall), .we_lo(we_lo), .we_hi(we_hi),
    .rdy_n(rdy_n), .rdata_oe(rdata_oe)
);

// File: tb/hdio_port_tb.sv
module hdio_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic [3:0]  rsel = '0;
    logic        bhe_n = 1'b1;
    logic        as_i = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        rdata_oe;
    logic        rdy_n;

    int compared = 0;
    int mismatched = 0;
    logic [15:0] model [8];
    logic [15:0] exp_q [$];
    string       tag_q [$];
    logic        oe_prev = 1'b0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    hdio_port u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rsel(rsel), .bhe_n(bhe_n),
        .as_i(as_i), .rd_n(rd_n), .wr_n(wr_n), .wdata(wdata),
        .rdata(rdata), .rdata_oe(rdata_oe), .rdy_n(rdy_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_rdy(input logic lvl, input string req);
        int t = 0;
        while (rdy_n !== lvl && t < 50) begin
            @(negedge clk);
            t++;
        end
        check({req, " ready level"}, rdy_n, lvl);
    endtask

    // Presents the address phase; latched=1 drops the strobe and scrambles the selects
    task automatic addr_phase(input logic c, input logic [3:0] a, input logic b, input bit latched);
        @(negedge clk);
        cs_n = c; rsel = a; bhe_n = b; as_i = 1'b1;
        idle(4);
        if (latched) begin
            as_i = 1'b0;
            idle(4);
            cs_n = ~c; rsel = ~a; bhe_n = ~b;
            idle(2);
        end
    endtask

    task automatic end_phase;
        idle(2);
        as_i = 1'b1;
        cs_n = 1'b1;
        idle(4);
    endtask

    task automatic do_write(input logic [3:0] a, input logic b, input logic [15:0] d,
                            input bit latched, input string req);
        addr_phase(1'b0, a, b, latched);
        wdata = d;
        idle(1);
        wr_n = 1'b0;
        wait_rdy(1'b0, req);
        idle(2);
        wr_n = 1'b1;
        wait_rdy(1'b1, "R8");
        if (!b && !a[0]) model[a[3:1]] = d;
        else if (a[0])   model[a[3:1]][15:8] = d[15:8];
        else             model[a[3:1]][7:0]  = d[7:0];
        end_phase();
    endtask

    task automatic do_read(input logic [3:0] a, input bit latched, input string req);
        addr_phase(1'b0, a, 1'b0, latched);
        exp_q.push_back(model[a[3:1]]);
        tag_q.push_back(req);
        rd_n = 1'b0;
        wait_rdy(1'b0, "R7");
        idle(2);
        rd_n = 1'b1;
        wait_rdy(1'b1, "R8");
        end_phase();
    endtask

    // Access with chip select high: no ready, no enable, no register change
    task automatic stray(input bit is_rd);
        bit seen = 1'b0;
        addr_phase(1'b1, 4'h4, 1'b0, 1'b1);
        wdata = 16'hDEAD;
        if (is_rd) rd_n = 1'b0; else wr_n = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!rdy_n || rdata_oe) seen = 1'b1;
        end
        rd_n = 1'b1; wr_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (!rdy_n || rdata_oe) seen = 1'b1;
        end
        check(is_rd ? "R7 deselected read no ready" : "R5 deselected write no ready", seen, 1'b0);
        end_phase();
    endtask

    // Monitor: on each rise of the output enable, compare against the scoreboard head
    always @(negedge clk) begin
        if (rdata_oe && !oe_prev) begin
            if (exp_q.size() == 0) begin
                check("R6 unexpected enable", 1, 0);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, rdata, e);
            end
        end
        if (!rdata_oe) begin
            if (rdata !== 16'h0) check("R6 idle bus zero", rdata, 0);
        end
        oe_prev <= rdata_oe;
    end

    initial begin
        for (int i = 0; i < 8; i++) model[i] = '0;
        idle(4);
        check("R10 reset ready", rdy_n, 1'b1);
        check("R10 reset enable", rdata_oe, 1'b0);
        rst_n = 1'b1;
        idle(4);
        do_read(4'h6, 1'b1, "R10 register resets to zero");
        do_write(4'h2, 1'b0, 16'hA5C3, 1'b1, "R9 word write");
        do_read(4'h2, 1'b1, "R9 word write readback");
        do_write(4'h3, 1'b0, 16'h7E11, 1'b1, "R9 odd byte write");
        do_read(4'h2, 1'b1, "R9 odd address high lane only");
        do_write(4'h2, 1'b1, 16'hFF42, 1'b1, "R9 even byte write");
        do_read(4'h2, 1'b1, "R9 even address low lane only");
        do_write(4'hE, 1'b0, 16'h1234, 1'b1, "R4 top word");
        do_write(4'h0, 1'b0, 16'h5678, 1'b1, "R4 bottom word");
        do_read(4'hE, 1'b1, "R4 word index from bits 3..1");
        do_read(4'h1, 1'b1, "R4 odd select reads same word");
        do_write(4'h8, 1'b0, 16'hBEEF, 1'b0, "R3 transparent write");
        do_read(4'h8, 1'b0, "R3 transparent readback");
        do_read(4'hE, 1'b1, "R2 latched select ignores later changes");
        stray(1'b0);
        do_read(4'h4, 1'b1, "R5 deselected write left register");
        stray(1'b1);
        do_write(4'hA, 1'b0, 16'h0F0F, 1'b1, "R5 write commit");
        do_read(4'hA, 1'b0, "R1 transparent select after latch cycle");
        idle(6);
        check("R6 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog actual=timeout expected=done");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule